// File: doc/BRIEF.md
# Reset Cause Recorder and Address-Zero Remap Control

This peripheral keeps a record of why the system last left reset and selects which memory answers at address zero. It watches three reset inputs (power-on, external pin and watchdog timeout) and holds sticky cause flags. The flags survive every reset except power-on, so a reset handler can read them afterwards. Software can also start a reset by writing the status register. The block then sends a one-cycle request to the reset generator and records the software cause.

Three word registers sit on a simple 32-bit bus with a one-cycle read latency. The remap register is at byte offset 0x0, the status register at 0x4 and the write-one-to-clear register at 0x8. The remap register has a control bit that places SRAM at address zero. Every reset clears this bit, so flash is back at address zero after any reset. The same register has two read-only flags, set by parameters, that report reduced memory sizes. A status value of zero means the last reset came from the external pin.

Top module: `rstc_top`

## Requirements
- R1: While `por_n` is low and on the cycles after it, the status register reads 0x00000001, the remap register reads only its two size flags, and `remap_o` and `swr_req_o` are 0.
- R2: A power-on reset clears status bits 1 and 2 as it sets bit 0, whatever their earlier values.
- R3: A cycle with `wdog_rst_i` high sets status bit 1 and leaves bits 0 and 2 unchanged.
- R4: An external reset (`ext_rst_n` low) sets no status bit and leaves the status register unchanged.
- R5: Writing the status register with data bit 2 set sets status bit 2 and raises `swr_req_o` for exactly one cycle, on the cycle after the write. Writes to status bits 0 and 1 have no effect.
- R6: Writing the clear register clears each status bit (0 = power-on, 1 = watchdog, 2 = software) whose data bit is 1. Writing 0x07 clears all three. The clear register reads as zero.
- R7: When a status bit is set and cleared in the same cycle, it ends up set.
- R8: Writing the remap register drives `remap_o` from data bit 0 on the following cycle. Bit 0 reads back the same value.
- R9: Any reset clears the remap bit: power-on, external, watchdog, and the software request (on the cycle after the `swr_req_o` pulse).
- R10: Remap bit 4 reads the parameter FLASH_HALF and bit 3 reads SRAM_HALF, and writes to them are ignored. Remap bits 2:1, status bits 31:3 and the other remap bits above 4 read as zero.
- R11: Read data appears on `bus_rdata` one cycle after the read request. Offsets not assigned to a register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n | input | 1 | External pin reset, synchronous, active low |
| wdog_rst_i | input | 1 | Watchdog timeout reset, active high |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| swr_req_o | output | 1 | One-cycle software reset request |
| remap_o | output | 1 | 1 selects SRAM at address zero |

## Verification
The bench builds the block with FLASH_HALF = 1 and SRAM_HALF = 0. With these values the two read-only size flags take different values, so a swapped bit position or a dropped flag shows up in the remap readback. This setting also lets the bench check that a write of all ones does not disturb those bits. The default of zero for both flags would hide such faults.

// File: rtl/rstc_pkg.sv
// Shared constants for the reset cause recorder.
// Assumes word-aligned byte offsets on a 32-bit register bus.
package rstc_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned CAUSE_W = 3;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_REMAP  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 4'h8;

    // Cause flag positions (software decodes these)
    localparam int unsigned BIT_POR  = 0;
    localparam int unsigned BIT_WDOG = 1;
    localparam int unsigned BIT_SOFT = 2;

    // Remap register field positions
    localparam int unsigned RM_SEL        = 0;
    localparam int unsigned RM_SRAM_HALF  = 3;
    localparam int unsigned RM_FLASH_HALF = 4;

    // Decoded single-cycle bus strobes
    typedef struct packed {
        logic wr_remap;
        logic wr_status;
        logic wr_clear;
        logic rd;
    } bus_dec_t;
endpackage

// File: rtl/rstc_regif.sv
// Register interface: decodes bus strobes and returns registered read data.
// Assumes bus_en is low during power-on or external reset; accesses then are ignored.
module rstc_regif
    import rstc_pkg::*;
#(
    parameter bit FLASH_HALF = 1'b0,
    parameter bit SRAM_HALF  = 1'b0
) (
    input  logic                clk,
    input  logic                bus_en,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CAUSE_W-1:0]  cause_flags,
    input  logic                remap_sel,
    output bus_dec_t            dec,
    output logic [BUS_W-1:0]    rdata
);
    logic [BUS_W-1:0] rd_word;

    // Decode the current access into one-hot write strobes and a read strobe
    always_comb begin
        dec           = '0;
        dec.rd        = bus_en & bus_req & ~bus_we;
        dec.wr_remap  = bus_en & bus_req & bus_we & (bus_addr == OFF_REMAP);
        dec.wr_status = bus_en & bus_req & bus_we & (bus_addr == OFF_STATUS);
        dec.wr_clear  = bus_en & bus_req & bus_we & (bus_addr == OFF_CLEAR);
    end

    // Select the word for the addressed register; unassigned offsets give zero
    always_comb begin
        rd_word = '0;
        unique case (bus_addr)
            OFF_REMAP: begin
                rd_word[RM_SEL]        = remap_sel;
                rd_word[RM_SRAM_HALF]  = SRAM_HALF;
                rd_word[RM_FLASH_HALF] = FLASH_HALF;
            end
            OFF_STATUS: rd_word[CAUSE_W-1:0] = cause_flags;
            default:    rd_word = '0;
        endcase
    end

    // Register the read data so it is valid one cycle after the request
    always_ff @(posedge clk) begin
        if (!bus_en) begin
            rdata <= '0;
        end else if (dec.rd) begin
            rdata <= rd_word;
        end
    end
endmodule

// File: rtl/rstc_cause.sv
// Sticky reset cause flags and the software reset request.
// Assumes por_n is synchronous; only power-on resets the flags.
module rstc_cause
    import rstc_pkg::*;
(
    input  logic                clk,
    input  logic                por_n,
    input  logic                wdog_rst_i,
    input  logic                wr_status,
    input  logic                wr_clear,
    input  logic [CAUSE_W-1:0]  wdata,
    output logic [CAUSE_W-1:0]  flags,
    output logic                swr_req
);
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;
    logic               soft_set;

    // A software request is accepted only when no request is already pulsing
    assign soft_set = wr_status & wdata[BIT_SOFT] & ~swr_req;

    // Gather this cycle's set and clear requests per cause bit
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_WDOG] = wdog_rst_i;
        set_vec[BIT_SOFT] = soft_set;
        clr_vec           = wr_clear ? wdata : '0;
    end

    // Update the flags: power-on restarts at 001, otherwise set beats clear
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flags          <= '0;
            flags[BIT_POR] <= 1'b1;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    // Produce a single-cycle software reset request
    always_ff @(posedge clk) begin
        if (!por_n) begin
            swr_req <= 1'b0;
        end else begin
            swr_req <= soft_set;
        end
    end
endmodule

// File: rtl/rstc_remap.sv
// Address-zero remap control bit; any reset returns flash to address zero.
// Assumes any_rst combines every reset source including the software request.
module rstc_remap (
    input  logic clk,
    input  logic any_rst,
    input  logic wr_remap,
    input  logic wdata_sel,
    output logic remap_sel
);
    // Hold the remap bit; resets take priority over a write
    always_ff @(posedge clk) begin
        if (any_rst) begin
            remap_sel <= 1'b0;
        end else if (wr_remap) begin
            remap_sel <= wdata_sel;
        end
    end
endmodule

// File: rtl/rstc_top.sv
// Reset cause recorder and remap controller top level.
// Assumes all reset inputs are already synchronous to clk.
module rstc_top
    import rstc_pkg::*;
#(
    parameter bit FLASH_HALF = 1'b0,
    parameter bit SRAM_HALF  = 1'b0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wdog_rst_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              swr_req_o,
    output logic              remap_o
);
    bus_dec_t           dec;
    logic               bus_en;
    logic               any_rst;
    logic [CAUSE_W-1:0] cause_flags;
    logic               unused_wdata_hi;

    // Bus accesses are live only outside power-on and external reset
    assign bus_en  = por_n & ext_rst_n;
    // Every reset source, including the software request, clears the remap bit
    assign any_rst = ~por_n | ~ext_rst_n | wdog_rst_i | swr_req_o;
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CAUSE_W];

    rstc_regif #(
        .FLASH_HALF (FLASH_HALF),
        .SRAM_HALF  (SRAM_HALF)
    ) u_regif (
        .clk         (clk),
        .bus_en      (bus_en),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .cause_flags (cause_flags),
        .remap_sel   (remap_o),
        .dec         (dec),
        .rdata       (bus_rdata)
    );

    rstc_cause u_cause (
        .clk        (clk),
        .por_n      (por_n),
        .wdog_rst_i (wdog_rst_i),
        .wr_status  (dec.wr_status),
        .wr_clear   (dec.wr_clear),
        .wdata      (bus_wdata[CAUSE_W-1:0]),
        .flags      (cause_flags),
        .swr_req    (swr_req_o)
    );

    rstc_remap u_remap (
        .clk       (clk),
        .any_rst   (any_rst),
        .wr_remap  (dec.wr_remap),
        .wdata_sel (bus_wdata[RM_SEL]),
        .remap_sel (remap_o)
    );
endmodule

// File: rtl/rstc_chk.sv
// Property checker for rstc_top, attached by bind.
// Assumes the flags input is the top level's cause_flags vector.
module rstc_chk (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       wdog_rst_i,
    input logic       swr_req_o,
    input logic       remap_o,
    input logic [2:0] flags
);
    assert_por_value_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (flags == 3'b001));

    assert_wdog_sets_R3: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst_i |=> flags[1]);

    assert_ext_keeps_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_rst_n && !wdog_rst_i) |=> (flags == $past(flags)));

    assert_swr_single_R5: assert property (@(posedge clk) disable iff (!por_n)
        swr_req_o |=> !swr_req_o);

    assert_swr_flag_R5: assert property (@(posedge clk) disable iff (!por_n)
        swr_req_o |-> flags[2]);

    assert_remap_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_rst_n || wdog_rst_i || swr_req_o) |=> !remap_o);
endmodule

bind rstc_top rstc_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .wdog_rst_i (wdog_rst_i),
    .swr_req_o  (swr_req_o),
    .remap_o    (remap_o),
    .flags      (cause_flags)
);

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        wdog_rst_i = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        swr_req_o;
    logic        remap_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstc_top #(.FLASH_HALF(1'b1), .SRAM_HALF(1'b0)) dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_rst_i(wdog_rst_i),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .swr_req_o(swr_req_o), .remap_o(remap_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_por();
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pulse_por();
        check("R1 remap_o after POR", {31'b0, remap_o}, 32'h0);
        check("R1 swr_req_o after POR", {31'b0, swr_req_o}, 32'h0);
        bus_read(4'h4, d); check("R1 status after POR", d, 32'h1);
        bus_read(4'h0, d); check("R1 R10 remap read after POR", d, 32'h10);
    endtask

    task automatic t_remap();
        logic [31:0] d;
        bus_write(4'h0, 32'hFFFF_FFFF);
        check("R8 remap_o set", {31'b0, remap_o}, 32'h1);
        bus_read(4'h0, d); check("R10 size flags and reserved after write", d, 32'h11);
        bus_write(4'h0, 32'h0);
        check("R8 remap_o cleared by write", {31'b0, remap_o}, 32'h0);
    endtask

    task automatic t_clear_read();
        logic [31:0] d;
        bus_write(4'h8, 32'h1);
        bus_read(4'h4, d); check("R6 POR flag cleared", d, 32'h0);
        bus_read(4'h8, d); check("R6 clear reg reads zero", d, 32'h0);
    endtask

    task automatic t_status_ro();
        logic [31:0] d;
        bus_write(4'h4, 32'h3);
        check("R5 no swr on bits 1:0", {31'b0, swr_req_o}, 32'h0);
        bus_read(4'h4, d); check("R5 bits 1:0 not writable", d, 32'h0);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        bus_write(4'h0, 32'h1);
        pulse_ext();
        check("R9 ext clears remap", {31'b0, remap_o}, 32'h0);
        bus_read(4'h4, d); check("R4 ext sets no flag", d, 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] d;
        bus_write(4'h0, 32'h1);
        @(negedge clk); wdog_rst_i = 1'b1;
        @(negedge clk); wdog_rst_i = 1'b0;
        check("R9 wdog clears remap", {31'b0, remap_o}, 32'h0);
        bus_read(4'h4, d); check("R3 wdog flag", d, 32'h2);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        bus_write(4'h0, 32'h1);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h4;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        check("R5 swr pulse high", {31'b0, swr_req_o}, 32'h1);
        check("R9 remap held during pulse", {31'b0, remap_o}, 32'h1);
        @(negedge clk);
        check("R5 swr pulse one cycle", {31'b0, swr_req_o}, 32'h0);
        check("R9 soft reset clears remap", {31'b0, remap_o}, 32'h0);
        bus_read(4'h4, d); check("R3 R5 soft flag kept with wdog", d, 32'h6);
    endtask

    task automatic t_ext_keeps();
        logic [31:0] d;
        pulse_ext();
        bus_read(4'h4, d); check("R4 ext leaves flags", d, 32'h6);
    endtask

    task automatic t_clear_bits();
        logic [31:0] d;
        bus_write(4'h8, 32'h2);
        bus_read(4'h4, d); check("R6 clear one bit", d, 32'h4);
        bus_write(4'h4, 32'h4);
        @(negedge clk);
        bus_write(4'h8, 32'h7);
        bus_read(4'h4, d); check("R6 clear all", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        wdog_rst_i = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h2;
        @(negedge clk);
        wdog_rst_i = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        bus_read(4'h4, d); check("R7 set wins over clear", d, 32'h2);
    endtask

    task automatic t_por_clears();
        logic [31:0] d;
        bus_write(4'h4, 32'h4);
        @(negedge clk);
        bus_read(4'h4, d); check("R2 flags before POR", d, 32'h6);
        pulse_por();
        bus_read(4'h4, d); check("R2 POR clears other flags", d, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(4'h4, d); check("R11 one-cycle read", d, 32'h1);
        bus_read(4'hC, d); check("R11 unmapped reads zero", d, 32'h0);
    endtask

    initial begin
        t_reset();
        t_remap();
        t_clear_read();
        t_status_ro();
        t_ext();
        t_wdog();
        t_soft();
        t_ext_keeps();
        t_clear_bits();
        t_set_wins();
        t_por_clears();
        t_unmapped();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule